// File: doc/BRIEF.md
# Banked USB OUT Endpoint Receive Buffer

This block holds the data a USB host sends to one OUT endpoint of a device and hands it to the local processor. It has one or two 64-byte banks. On the host side it sees an OUT token strobe, a stream of packet bytes and an end-of-packet strobe. After each packet it returns a handshake: ACK when the packet landed in a free bank, and NAK when no bank was free. The data of a NAKed packet is thrown away, and the host is expected to retry.

On the processor side the block looks like a small register set. It has a receive flag with an interrupt enable, a write-one-to-clear acknowledge, and an ownership bit that only hardware can set. While software owns a bank, it can see that bank's byte count and a read-allowed flag, and it pulls bytes through a sequential data port. Clearing the ownership bit hands the bank back to the host side and moves software to the other bank. With two banks, the host fills one bank while software drains the other. When the next bank is already full at the moment of release, ownership and the receive flag come back one cycle later.

Top module: `usb_out_ep_buf`

## Requirements
- R1: After reset, the ownership bit, receive flag, interrupt, read-allowed flag and byte count all read zero.
- R2: A packet whose token found the fill bank free is answered with a one-cycle handshake pulse carrying ACK (ack bit 1). The pulse appears on the first clock edge after the end-of-packet strobe is sampled.
- R3: A packet whose token found the fill bank full is answered with NAK (ack bit 0). Its bytes are discarded, and the state and data of every bank are left as they were.
- R4: Completing an accepted packet sets both the receive flag and the ownership bit on the second rising edge after the end-of-packet strobe is sampled, provided software owns no bank at that time.
- R5: The interrupt output is high exactly when the receive flag is set and the interrupt enable input is 1.
- R6: An acknowledge write with data 1 clears the receive flag. An acknowledge write with data 0 leaves it unchanged.
- R7: While software owns a bank, the byte count output shows the number of unread bytes in that bank. Otherwise it reads zero.
- R8: The data port shows the next unread byte, in arrival order. Each read strobe while read-allowed is high advances to the following byte and lowers the count by one. When the count reaches zero, read-allowed drops, and further read strobes have no effect.
- R9: A write of 0 to the ownership bit frees the owned bank. A write of 1 is ignored: it cannot set the bit.
- R10: With two banks, a packet sent while software owns one bank is accepted into the other bank. Banks are filled and handed to software in strict alternation.
- R11: When software frees a bank while the other bank is full, the ownership bit reads 0 for exactly one cycle and then reads 1 together with a set receive flag.
- R12: A packet longer than 64 bytes keeps only its first 64 bytes, and the byte count saturates at 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_tok_i | input | 1 | OUT token strobe that starts a packet |
| host_vld_i | input | 1 | Packet byte valid |
| host_byte_i | input | 8 | Packet byte |
| host_eop_i | input | 1 | End-of-packet strobe; a byte valid in the same cycle is included |
| host_hs_valid_o | output | 1 | Handshake pulse |
| host_hs_ack_o | output | 1 | Handshake kind: 1 is ACK, 0 is NAK |
| cpu_int_en_i | input | 1 | Receive interrupt enable |
| cpu_ack_wr_i | input | 1 | Acknowledge register write strobe |
| cpu_ack_val_i | input | 1 | Acknowledge write data; 1 clears the receive flag |
| cpu_fc_wr_i | input | 1 | Ownership bit write strobe |
| cpu_fc_val_i | input | 1 | Ownership write data; 0 frees the owned bank |
| cpu_rd_i | input | 1 | Data port read strobe |
| cpu_rd_data_o | output | 8 | Next unread byte of the owned bank |
| cpu_rxout_o | output | 1 | Receive flag |
| cpu_fifocon_o | output | 1 | Ownership bit: software holds a bank |
| cpu_rwall_o | output | 1 | Read allowed: owned bank has unread bytes |
| cpu_bytecnt_o | output | 7 | Unread byte count of the owned bank |
| cpu_int_o | output | 1 | Endpoint interrupt |

## Verification
The embedded properties check several rules on every cycle. A bank that is already full is never committed to, and a token that meets a full bank always leads to the discard state. Every granted read lowers the count by one, and the count never exceeds the bank size. An ACK pulse always follows a commit. Software cannot set the ownership bit, a clearing acknowledge takes effect, and a release with the other bank full re-arms ownership after one cycle. What only the bench scenarios can show is the end-to-end content and ordering. Bytes read out must match what the host sent, packet by packet, across the bank alternation. A NAKed packet must leave no trace in the data that is later drained, and an overlong packet must be truncated correctly.

// File: rtl/usb_out_ep_pkg.sv
// Shared types for the banked OUT endpoint buffer.
package usb_out_ep_pkg;

    // Host-side reception state: waiting for a token, storing a packet, or
    // swallowing a packet that found no free bank.
    typedef enum logic [1:0] {
        FILL_IDLE = 2'd0,
        FILL_RECV = 2'd1,
        FILL_DROP = 2'd2
    } fill_state_e;

endpackage

// File: rtl/ep_bank.sv
// One data bank: a byte array, a byte counter and a full flag.
// The host side writes at the counter position. The CPU side reads at an
// external index and counts down. Assumes the two sides never work on the
// same bank at once (the control logic guarantees this).
module ep_bank #(
    parameter int BYTES = 64,
    parameter int CNT_W = 7,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_start,
    input  logic             wr_en,
    input  logic [7:0]       wr_byte,
    input  logic             commit,
    input  logic             free_i,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic [CNT_W-1:0] count,
    output logic             full
);

    localparam logic [CNT_W-1:0] CAP = CNT_W'(BYTES);

    logic [7:0] mem [BYTES];
    logic       room;

    assign room    = (count < CAP);
    assign rd_data = mem[rd_idx];

    // Store an incoming byte at the current fill position.
    always_ff @(posedge clk) begin
        if (wr_en && room) begin
            mem[count[IDX_W-1:0]] <= wr_byte;
        end
    end

    // Byte counter: cleared at packet start, up on write, down on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr_start) begin
            count <= '0;
        end else if (wr_en && room) begin
            count <= count + 1'b1;
        end else if (rd_en && (count != '0)) begin
            count <= count - 1'b1;
        end
    end

    // Full flag: set by a packet commit, cleared by software release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
        end else if (commit) begin
            full <= 1'b1;
        end else if (free_i) begin
            full <= 1'b0;
        end
    end

    // R3: the host never commits into a bank that is already full.
    p_commit_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !full);

    // R8: each granted read lowers the count by exactly one.
    p_read_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (count != '0) && !wr_en && !wr_start) |=> (count == $past(count) - 1'b1));

    // R12: the count never exceeds the bank size.
    p_cap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CAP);

endmodule

// File: rtl/ep_host_fill.sv
// Host-side reception control. A token either claims the current fill bank
// (when it is free) or marks the packet for discard. End of packet commits
// the bank, advances the fill pointer and answers ACK, or answers NAK.
// Assumes bytes arrive after the token, and that a byte may share its cycle
// with end of packet.
module ep_host_fill
    import usb_out_ep_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BYTES     = 64,
    parameter int CNT_W     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok,
    input  logic             vld,
    input  logic             eop,
    input  logic [1:0]       full_vec,
    input  logic [CNT_W-1:0] cnt_fill,
    output logic             fb,
    output logic             wr_start,
    output logic             wr_en,
    output logic             commit,
    output logic             hs_valid,
    output logic             hs_ack
);

    localparam logic [CNT_W-1:0] CAP = CNT_W'(BYTES);

    fill_state_e state;
    logic        fill_full;
    logic        drop_end;

    assign fill_full = full_vec[fb];
    assign wr_start  = (state == FILL_IDLE) && tok && !fill_full;
    assign wr_en     = (state == FILL_RECV) && vld && (cnt_fill < CAP);
    assign commit    = (state == FILL_RECV) && eop;
    assign drop_end  = (state == FILL_DROP) && eop;

    // Reception state sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FILL_IDLE;
        end else begin
            case (state)
                FILL_IDLE: if (tok) state <= fill_full ? FILL_DROP : FILL_RECV;
                FILL_RECV: if (eop) state <= FILL_IDLE;
                FILL_DROP: if (eop) state <= FILL_IDLE;
                default:   state <= FILL_IDLE;
            endcase
        end
    end

    // Fill pointer: moves to the other bank after each commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb <= 1'b0;
        end else if (commit && (NUM_BANKS == 2)) begin
            fb <= ~fb;
        end
    end

    // Handshake pulse, registered one edge after end of packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_valid <= 1'b0;
            hs_ack   <= 1'b0;
        end else begin
            hs_valid <= commit || drop_end;
            hs_ack   <= commit;
        end
    end

    // R3: a token meeting a full bank leads to discard.
    p_nak_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == FILL_IDLE) && tok && fill_full) |=> (state == FILL_DROP));

    // R2: an ACK pulse is always preceded by a commit.
    p_ack_after_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_ack) |-> $past(commit));

endmodule

// File: rtl/ep_cpu_ctrl.sv
// CPU-side control: ownership bit, receive flag, interrupt, read pointer and
// bank hand-back. Ownership is taken by hardware when the current CPU bank
// is full. Software gives it back by writing 0. Assumes the full flags come
// from the banks and change only through commit and release.
module ep_cpu_ctrl #(
    parameter int NUM_BANKS = 2,
    parameter int CNT_W     = 7,
    parameter int IDX_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       full_vec,
    input  logic [CNT_W-1:0] cnt_cur,
    input  logic             rd_i,
    input  logic             clr_wr,
    input  logic             clr_val,
    input  logic             fc_wr,
    input  logic             fc_val,
    input  logic             int_en,
    output logic             cb,
    output logic             free_pulse,
    output logic             rd_en,
    output logic [IDX_W-1:0] rptr,
    output logic             fifocon,
    output logic             rxout,
    output logic             int_o,
    output logic             rwall,
    output logic [CNT_W-1:0] bytecnt
);

    logic take;

    assign take       = !fifocon && full_vec[cb];
    assign free_pulse = fc_wr && !fc_val && fifocon;
    assign rwall      = fifocon && (cnt_cur != '0);
    assign rd_en      = rd_i && rwall;
    assign bytecnt    = fifocon ? cnt_cur : '0;
    assign int_o      = rxout && int_en;

    // Ownership bit: hardware sets, a software 0-write clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifocon <= 1'b0;
        end else if (free_pulse) begin
            fifocon <= 1'b0;
        end else if (take) begin
            fifocon <= 1'b1;
        end
    end

    // Receive flag: raised with ownership, cleared by a one-write acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxout <= 1'b0;
        end else if (take) begin
            rxout <= 1'b1;
        end else if (clr_wr && clr_val) begin
            rxout <= 1'b0;
        end
    end

    // CPU bank pointer: moves to the other bank on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cb <= 1'b0;
        end else if (free_pulse && (NUM_BANKS == 2)) begin
            cb <= ~cb;
        end
    end

    // Read index into the owned bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr <= '0;
        end else if (free_pulse) begin
            rptr <= '0;
        end else if (rd_en) begin
            rptr <= rptr + 1'b1;
        end
    end

    // R9: writing 1 cannot raise the ownership bit.
    p_sw_set_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_wr && fc_val && !fifocon && !full_vec[cb]) |=> !fifocon);

    // R11: a release with the other bank full re-arms after one idle cycle.
    p_rearm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((NUM_BANKS == 2) && free_pulse && full_vec[~cb]) |=> (!fifocon ##1 (fifocon && rxout)));

    // R6: a one-write acknowledge clears the flag unless a new take coincides.
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_val && !take) |=> !rxout);

    // R4: the receive flag never rises without ownership.
    p_flag_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rxout) |-> fifocon);

endmodule

// File: rtl/usb_out_ep_buf.sv
// Banked OUT endpoint receive buffer, top level. Connects the host-side
// fill control, one or two data banks and the CPU-side control. Assumes
// NUM_BANKS is 1 or 2 and BANK_BYTES is a power of two.
module usb_out_ep_buf #(
    parameter int NUM_BANKS  = 2,
    parameter int BANK_BYTES = 64,
    localparam int CNT_W     = $clog2(BANK_BYTES + 1),
    localparam int IDX_W     = $clog2(BANK_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_tok_i,
    input  logic             host_vld_i,
    input  logic [7:0]       host_byte_i,
    input  logic             host_eop_i,
    output logic             host_hs_valid_o,
    output logic             host_hs_ack_o,
    input  logic             cpu_int_en_i,
    input  logic             cpu_ack_wr_i,
    input  logic             cpu_ack_val_i,
    input  logic             cpu_fc_wr_i,
    input  logic             cpu_fc_val_i,
    input  logic             cpu_rd_i,
    output logic [7:0]       cpu_rd_data_o,
    output logic             cpu_rxout_o,
    output logic             cpu_fifocon_o,
    output logic             cpu_rwall_o,
    output logic [CNT_W-1:0] cpu_bytecnt_o,
    output logic             cpu_int_o
);

    logic             fb, cb;
    logic             wr_start, wr_en, commit, free_pulse, rd_en;
    logic [IDX_W-1:0] rptr;
    logic [1:0]       full_vec;
    logic [CNT_W-1:0] cnt_arr  [2];
    logic [7:0]       rdat_arr [2];

    ep_host_fill #(
        .NUM_BANKS (NUM_BANKS),
        .BYTES     (BANK_BYTES),
        .CNT_W     (CNT_W)
    ) u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .tok      (host_tok_i),
        .vld      (host_vld_i),
        .eop      (host_eop_i),
        .full_vec (full_vec),
        .cnt_fill (cnt_arr[fb]),
        .fb       (fb),
        .wr_start (wr_start),
        .wr_en    (wr_en),
        .commit   (commit),
        .hs_valid (host_hs_valid_o),
        .hs_ack   (host_hs_ack_o)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        if (b < NUM_BANKS) begin : g_live
            ep_bank #(
                .BYTES (BANK_BYTES),
                .CNT_W (CNT_W),
                .IDX_W (IDX_W)
            ) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_start (wr_start && (fb == 1'(b))),
                .wr_en    (wr_en && (fb == 1'(b))),
                .wr_byte  (host_byte_i),
                .commit   (commit && (fb == 1'(b))),
                .free_i   (free_pulse && (cb == 1'(b))),
                .rd_en    (rd_en && (cb == 1'(b))),
                .rd_idx   (rptr),
                .rd_data  (rdat_arr[b]),
                .count    (cnt_arr[b]),
                .full     (full_vec[b])
            );
        end else begin : g_absent
            assign rdat_arr[b] = '0;
            assign cnt_arr[b]  = '0;
            assign full_vec[b] = 1'b0;
        end
    end

    ep_cpu_ctrl #(
        .NUM_BANKS (NUM_BANKS),
        .CNT_W     (CNT_W),
        .IDX_W     (IDX_W)
    ) u_cpu (
        .clk        (clk),
        .rst_n      (rst_n),
        .full_vec   (full_vec),
        .cnt_cur    (cnt_arr[cb]),
        .rd_i       (cpu_rd_i),
        .clr_wr     (cpu_ack_wr_i),
        .clr_val    (cpu_ack_val_i),
        .fc_wr      (cpu_fc_wr_i),
        .fc_val     (cpu_fc_val_i),
        .int_en     (cpu_int_en_i),
        .cb         (cb),
        .free_pulse (free_pulse),
        .rd_en      (rd_en),
        .rptr       (rptr),
        .fifocon    (cpu_fifocon_o),
        .rxout      (cpu_rxout_o),
        .int_o      (cpu_int_o),
        .rwall      (cpu_rwall_o),
        .bytecnt    (cpu_bytecnt_o)
    );

    assign cpu_rd_data_o = rdat_arr[cb];

    // R5: the interrupt only ever accompanies a set receive flag.
    p_int_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_int_o |-> (cpu_rxout_o && cpu_int_en_i));

endmodule

// File: tb/usb_out_ep_buf_test.sv
// Scoreboard bench: the packet driver queues the expected handshakes and
// bytes; a handshake monitor and the drain task compare against them.
module usb_out_ep_buf_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tok = 1'b0, vld = 1'b0, eop = 1'b0;
    logic [7:0] hbyte = '0;
    logic       hs_valid, hs_ack;
    logic       int_en = 1'b0;
    logic       ack_wr = 1'b0, ack_val = 1'b0;
    logic       fc_wr = 1'b0, fc_val = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] rdata;
    logic       rxout, fifocon, rwall, irq;
    logic [6:0] bcnt;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0] exp_q [$];
    bit         hs_q  [$];

    always #5 clk = ~clk;

    usb_out_ep_buf uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .host_tok_i      (tok),
        .host_vld_i      (vld),
        .host_byte_i     (hbyte),
        .host_eop_i      (eop),
        .host_hs_valid_o (hs_valid),
        .host_hs_ack_o   (hs_ack),
        .cpu_int_en_i    (int_en),
        .cpu_ack_wr_i    (ack_wr),
        .cpu_ack_val_i   (ack_val),
        .cpu_fc_wr_i     (fc_wr),
        .cpu_fc_val_i    (fc_val),
        .cpu_rd_i        (rd),
        .cpu_rd_data_o   (rdata),
        .cpu_rxout_o     (rxout),
        .cpu_fifocon_o   (fifocon),
        .cpu_rwall_o     (rwall),
        .cpu_bytecnt_o   (bcnt),
        .cpu_int_o       (irq)
    );

    task automatic chk(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: every handshake pulse is compared with the next queued one.
    always @(negedge clk) begin
        if (rst_n && hs_valid) begin
            if (hs_q.size() == 0) begin
                chk("R2/R3 unexpected handshake", 1, 0);
            end else begin
                chk("R2/R3 handshake kind", int'(hs_ack), int'(hs_q.pop_front()));
            end
        end
    end

    // Driver: token, n bytes with eop on the last, queues expectations.
    task automatic send_pkt(int n, int base, bit exp_ack);
        hs_q.push_back(exp_ack);
        @(negedge clk);
        tok = 1'b1;
        @(negedge clk);
        tok = 1'b0;
        for (int i = 0; i < n; i++) begin
            vld   = 1'b1;
            hbyte = 8'(base + i);
            eop   = (i == n - 1);
            if (exp_ack && i < 64) exp_q.push_back(8'(base + i));
            @(negedge clk);
        end
        vld = 1'b0;
        eop = 1'b0;
    endtask

    // Drain n bytes from the owned bank, comparing against the queue.
    task automatic drain(int n);
        for (int i = 0; i < n; i++) begin
            chk("R8 read allowed", int'(rwall), 1);
            chk("R8 data order", int'(rdata), int'(exp_q.pop_front()));
            rd = 1'b1;
            @(negedge clk);
        end
        rd = 1'b0;
        chk("R8 read allowed drops at empty", int'(rwall), 0);
        chk("R8 count empty", int'(bcnt), 0);
    endtask

    task automatic write_fc(bit v);
        fc_wr  = 1'b1;
        fc_val = v;
        @(negedge clk);
        fc_wr  = 1'b0;
    endtask

    task automatic write_ack(bit v);
        ack_wr  = 1'b1;
        ack_val = v;
        @(negedge clk);
        ack_wr  = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1 (run completed)");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 fifocon", int'(fifocon), 0);
        chk("R1 rxout", int'(rxout), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 rwall", int'(rwall), 0);
        chk("R1 bytecnt", int'(bcnt), 0);

        // R2, R4, R5: single packet accepted, flags two edges after eop
        int_en = 1'b1;
        send_pkt(5, 8'h10, 1'b1);
        chk("R4 fifocon not yet", int'(fifocon), 0);
        @(negedge clk);
        chk("R4 fifocon set", int'(fifocon), 1);
        chk("R4 rxout set", int'(rxout), 1);
        chk("R5 irq with enable", int'(irq), 1);
        int_en = 1'b0;
        #1;
        chk("R5 irq masked", int'(irq), 0);
        int_en = 1'b1;
        // R6: zero write no effect, one write clears
        write_ack(1'b0);
        chk("R6 zero write keeps flag", int'(rxout), 1);
        write_ack(1'b1);
        chk("R6 one write clears flag", int'(rxout), 0);
        chk("R5 irq follows flag", int'(irq), 0);
        chk("R7 bytecnt", int'(bcnt), 5);
        drain(5);
        // R8: read at empty has no effect
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        chk("R8 extra read ignored", int'(bcnt), 0);
        write_fc(1'b0);
        chk("R9 release clears fifocon", int'(fifocon), 0);
        chk("R7 bytecnt zero when not owned", int'(bcnt), 0);
        write_fc(1'b1);
        @(negedge clk);
        chk("R9 one write ignored", int'(fifocon), 0);

        // R10: second packet lands while first is owned; R3: third is NAKed
        send_pkt(3, 8'h40, 1'b1);
        @(negedge clk);
        chk("R10 first owned", int'(fifocon), 1);
        write_ack(1'b1);
        send_pkt(4, 8'h80, 1'b1);
        @(negedge clk);
        chk("R10 owned bank count kept", int'(bcnt), 3);
        send_pkt(6, 8'hC0, 1'b0);
        @(negedge clk);
        chk("R3 count unchanged after NAK", int'(bcnt), 3);
        chk("R3 flag unchanged after NAK", int'(rxout), 0);
        drain(3);
        // R11: release with the other bank full
        write_fc(1'b0);
        chk("R11 fifocon low one cycle", int'(fifocon), 0);
        @(negedge clk);
        chk("R11 fifocon back", int'(fifocon), 1);
        chk("R11 rxout back", int'(rxout), 1);
        chk("R10 second packet count", int'(bcnt), 4);
        drain(4);
        write_fc(1'b0);
        write_ack(1'b1);

        // R12: overlong packet truncated at 64 bytes
        send_pkt(70, 8'h00, 1'b1);
        @(negedge clk);
        chk("R12 count saturates", int'(bcnt), 64);
        drain(64);
        write_fc(1'b0);
        @(negedge clk);
        chk("R2/R3 all handshakes seen", hs_q.size(), 0);
        chk("R8 all bytes drained", exp_q.size(), 0);

        done = 1'b1;
        finish_run();
    end

endmodule